// File: doc/BRIEF.md
# Embedded Transmit Command Interpreter

This block sits in a synchronous transmit path, between a per-channel byte FIFO and a byte-wide serializer. It watches the outgoing byte stream for an in-band four-byte command. Ordinary bytes pass straight through with no added latency, and valid/ready is carried through unchanged in both directions. A command byte is followed by three operand bytes: a control-lead setting, a character, and a repeat count. The interpreter consumes all four bytes. It then hands the character to the serializer the commanded number of times. The control lead changes when the first copy is accepted, so the lead change lines up with the data.

A repeat count of zero selects continuous repetition. The character is sent again and again for as long as the FIFO stays empty. Once new data is present, repetition stops at the next character boundary, but only after at least three copies have gone out. While it repeats, the block takes nothing from the FIFO. Command detection is gated by an enable input. With the enable low, the command code is ordinary data.

Top module: `txcmd_interp`

## Requirements
- R1: With no command in progress, a non-command byte from the FIFO is presented to the serializer unchanged in the same cycle, and `inReady` equals `outReady`.
- R2: With `cmdEn` high, a FIFO byte of value 0x80 starts a command. That byte and the next three FIFO bytes are accepted (`inReady` high) and none of them is ever presented on `outData`.
- R3: With `cmdEn` low, a 0x80 byte and the bytes after it are passed through as ordinary data.
- R4: Operand byte 2 = 0x00 selects lead low (0) and 0x01 selects lead high (1). `leadOut` takes the new level in the cycle after the first repeated character is accepted by the serializer, and not earlier.
- R5: Operand byte 2 values 0x02 to 0xFF leave `leadOut` unchanged, and the character is still repeated as commanded.
- R6: Operand byte 4 values 1 to 255 send operand byte 3, all 8 bits unmodified, exactly that many times.
- R7: Operand byte 4 = 0 repeats the character for as long as `fifoNotEmpty` is low. Repetition ends only at an accepted character once `fifoNotEmpty` is high.
- R8: In continuous mode, at least three copies are sent even if FIFO data is already waiting.
- R9: During repetition `inReady` is low, and `outValid`/`outData` hold steady while `outReady` is low.
- R10: After repetition ends, the next FIFO byte is handled normally, and it may start a new command.
- R11: After reset, `leadOut` is 0, the block is in pass-through, and `outValid` follows `inValid` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdEn | input | 1 | Enables detection of embedded commands |
| inData | input | 8 | Byte at the head of the FIFO |
| inValid | input | 1 | FIFO head byte is valid |
| inReady | output | 1 | Block takes the FIFO head byte this cycle |
| fifoNotEmpty | input | 1 | FIFO holds at least one byte |
| outData | output | 8 | Byte offered to the serializer |
| outValid | output | 1 | `outData` is valid |
| outReady | input | 1 | Serializer accepts `outData` this cycle |
| leadOut | output | 1 | Control-lead level |

## Verification
A corrupted parse state shows up at the ports within one cycle. An operand byte leaks onto `outData`, or `inReady` rises during repetition. A wrong repeat counter shows up as one copy too many or too few at the end of a repeat burst, before the next FIFO byte appears. A lead register that updates at parse time, rather than at the first accepted copy, is caught when the bench stalls `outReady`. A minimum-count error in continuous mode is caught when data is already queued behind the command.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;
  typedef enum logic [2:0] {
    ST_PASS,
    ST_LEAD,
    ST_CHAR,
    ST_COUNT,
    ST_REPEAT
  } state_e;

  typedef struct packed {
    logic capLead;
    logic capChar;
    logic capCount;
    logic sendRep;
  } strobe_t;
endpackage

// File: rtl/txcmd_ctrl.sv
module txcmd_ctrl
  import txcmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CMD_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              outReady,
  input  logic              lastSend,
  input  logic              contDone,
  output logic              inReady,
  output logic              outValid,
  output logic              repSel,
  output strobe_t           strb
);
  state_e state, stateNext;
  logic   isCmd;

  assign isCmd = cmdEn && (inData == CMD_CODE);

  always_comb begin
    stateNext = state;
    inReady   = 1'b0;
    outValid  = 1'b0;
    repSel    = 1'b0;
    strb      = '0;
    case (state)
      ST_PASS: begin
        if (inValid && isCmd) begin
          inReady   = 1'b1;
          stateNext = ST_LEAD;
        end else begin
          outValid = inValid;
          inReady  = outReady;
        end
      end
      ST_LEAD: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.capLead = 1'b1;
          stateNext    = ST_CHAR;
        end
      end
      ST_CHAR: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.capChar = 1'b1;
          stateNext    = ST_COUNT;
        end
      end
      ST_COUNT: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.capCount = 1'b1;
          stateNext     = ST_REPEAT;
        end
      end
      ST_REPEAT: begin
        outValid = 1'b1;
        repSel   = 1'b1;
        if (outReady) begin
          strb.sendRep = 1'b1;
          if (lastSend || contDone) stateNext = ST_PASS;
        end
      end
      default: stateNext = ST_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PASS;
    else       state <= stateNext;
  end

  // R9: a stalled repeat keeps offering the character
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REPEAT && !outReady) |=> (state == ST_REPEAT && outValid));

  // R3: with detection disabled the parser never leaves pass-through
  p_disabled_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS && !cmdEn) |=> (state == ST_PASS));
endmodule

// File: rtl/txcmd_dp.sv
module txcmd_dp
  import txcmd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_CONT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  strobe_t           strb,
  input  logic              fifoNotEmpty,
  output logic [DATA_W-1:0] repChar,
  output logic              leadOut,
  output logic              lastSend,
  output logic              contDone
);
  localparam logic [DATA_W-1:0] LEAD_OFF = DATA_W'(0);
  localparam logic [DATA_W-1:0] LEAD_ON  = DATA_W'(1);
  localparam logic [DATA_W-1:0] MIN_M1   = DATA_W'(MIN_CONT - 1);

  logic              leadPendValid;
  logic              leadPendVal;
  logic [DATA_W-1:0] countReg;
  logic [DATA_W-1:0] sentCnt;
  logic [DATA_W:0]   nextCnt;
  logic              contMode;

  assign contMode = (countReg == '0);
  assign nextCnt  = {1'b0, sentCnt} + 1'b1;
  assign lastSend = !contMode && (nextCnt == {1'b0, countReg});
  assign contDone = contMode && (sentCnt >= MIN_M1) && fifoNotEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leadPendValid <= 1'b0;
      leadPendVal   <= 1'b0;
      repChar       <= '0;
      countReg      <= '0;
      sentCnt       <= '0;
      leadOut       <= 1'b0;
    end else begin
      if (strb.capLead) begin
        leadPendValid <= (inData == LEAD_OFF) || (inData == LEAD_ON);
        leadPendVal   <= (inData == LEAD_ON);
      end
      if (strb.capChar) repChar <= inData;
      if (strb.capCount) begin
        countReg <= inData;
        sentCnt  <= '0;
      end
      if (strb.sendRep) begin
        if (sentCnt == '0 && leadPendValid) leadOut <= leadPendVal;
        if (!(contMode && sentCnt >= MIN_M1)) sentCnt <= sentCnt + 1'b1;
      end
    end
  end

  // R4: the lead moves only on an accepted repeat copy
  p_lead_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sendRep |=> $stable(leadOut));

  // R6: a counted burst never sends past its count
  p_sent_below_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sendRep && !contMode) |-> (sentCnt < countReg));
endmodule

// File: rtl/txcmd_interp.sv
module txcmd_interp
  import txcmd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_CONT = 3,
  parameter logic [DATA_W-1:0] CMD_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdEn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              fifoNotEmpty,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              leadOut
);
  strobe_t           strb;
  logic              repSel;
  logic              lastSend;
  logic              contDone;
  logic [DATA_W-1:0] repChar;

  txcmd_ctrl #(.DATA_W(DATA_W), .CMD_CODE(CMD_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdEn(cmdEn), .inData(inData),
    .inValid(inValid), .outReady(outReady), .lastSend(lastSend),
    .contDone(contDone), .inReady(inReady), .outValid(outValid),
    .repSel(repSel), .strb(strb)
  );

  txcmd_dp #(.DATA_W(DATA_W), .MIN_CONT(MIN_CONT)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strb(strb),
    .fifoNotEmpty(fifoNotEmpty), .repChar(repChar), .leadOut(leadOut),
    .lastSend(lastSend), .contDone(contDone)
  );

  assign outData = repSel ? repChar : inData;

  // R9: no FIFO byte is taken while a repeat copy is on offer
  p_no_take_in_repeat_r9: assert property (@(posedge clk) disable iff (!rstN)
    (repSel && outValid) |-> !inReady);
endmodule

// File: tb/txcmd_interp_tb.sv
module txcmd_interp_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdEn;
  logic [7:0] inData;
  logic       inValid;
  logic       inReady;
  logic       fifoNotEmpty;
  logic [7:0] outData;
  logic       outValid;
  logic       outReady;
  logic       leadOut;

  always #(CLK_P/2) clk = ~clk;

  txcmd_interp u_dut (
    .clk(clk), .rstN(rstN), .cmdEn(cmdEn), .inData(inData),
    .inValid(inValid), .inReady(inReady), .fifoNotEmpty(fifoNotEmpty),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .leadOut(leadOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit rdyPat  = 1'b0;
  string curReq = "R1";

  logic [7:0] fifoQ[$];
  logic [7:0] outLog[$];

  // behavioural reference state
  int mMode = 0;      // 0 pass, 1..3 operand index, 4 repeating
  int mLead = 0;
  int mPend = -1;
  int mChar = 0;
  int mCnt  = 0;
  int mSent = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit eOV, eRdy, hsIn, hsOut, isCmd;
    int eData;
    @(negedge clk);
    inValid      = fifoQ.size() > 0;
    inData       = inValid ? fifoQ[0] : 8'h00;
    fifoNotEmpty = inValid;
    outReady     = rdyPat ? ((cyc % 3) != 2) : 1'b1;
    cyc++;
    #1;
    eOV = 0; eRdy = 0; eData = 0;
    isCmd = inValid && cmdEn && (inData == 8'h80);
    if (mMode == 0) begin
      if (isCmd) eRdy = 1;
      else begin eOV = inValid; eRdy = outReady; eData = inData; end
    end else if (mMode < 4) begin
      eRdy = 1;
    end else begin
      eOV = 1; eData = mChar;
    end
    chk(outValid == eOV, curReq, "outValid", outValid, eOV);
    chk(inReady == eRdy, curReq, "inReady", inReady, eRdy);
    chk(leadOut == mLead[0], curReq, "leadOut", leadOut, mLead);
    if (eOV) chk(outData == eData[7:0], curReq, "outData", outData, eData);
    hsIn  = inValid && eRdy;
    hsOut = eOV && outReady;
    if (hsOut) outLog.push_back(outData);
    case (mMode)
      0: if (isCmd) mMode = 1;
      1: if (hsIn) begin
           mPend = (inData == 8'h00) ? 0 : (inData == 8'h01) ? 1 : -1;
           mMode = 2;
         end
      2: if (hsIn) begin mChar = inData; mMode = 3; end
      3: if (hsIn) begin mCnt = inData; mSent = 0; mMode = 4; end
      default: if (hsOut) begin
           if (mSent == 0 && mPend >= 0) mLead = mPend;
           mSent++;
           if (mCnt != 0 && mSent == mCnt) mMode = 0;
           if (mCnt == 0 && mSent >= 3 && fifoQ.size() > 0) mMode = 0;
         end
    endcase
    if (hsIn) void'(fifoQ.pop_front());
  endtask

  task automatic runIdle();
    int guard = 0;
    while ((fifoQ.size() > 0 || mMode != 0) && guard < 2000) begin
      step();
      guard++;
    end
    step();
  endtask

  task automatic chkLog(input string req, input logic [7:0] exp[$]);
    chk(outLog.size() == exp.size(), req, "output byte count", outLog.size(), exp.size());
    for (int i = 0; i < exp.size() && i < outLog.size(); i++)
      chk(outLog[i] == exp[i], req, "output byte", outLog[i], exp[i]);
    outLog.delete();
  endtask

  initial begin
    #(CLK_P * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] e[$];
    int n45;
    bit only45;
    rstN = 0; cmdEn = 1; inValid = 0; inData = 0; fifoNotEmpty = 0; outReady = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R11: reset state
    chk(leadOut == 1'b0, "R11", "leadOut after reset", leadOut, 0);
    chk(outValid == 1'b0, "R11", "outValid with empty FIFO", outValid, 0);

    // R1 plain pass-through
    curReq = "R1"; rdyPat = 1;
    fifoQ = '{8'h11, 8'h22, 8'h33};
    runIdle();
    e = '{8'h11, 8'h22, 8'h33}; chkLog("R1", e);

    // R3 command code as data when disabled
    curReq = "R3"; cmdEn = 0;
    fifoQ = '{8'h80, 8'h01, 8'h44, 8'h02};
    runIdle();
    e = '{8'h80, 8'h01, 8'h44, 8'h02}; chkLog("R3", e);
    chk(leadOut == 1'b0, "R3", "lead untouched", leadOut, 0);

    // R2, R4, R6 command with lead on, count 3
    curReq = "R2/R4/R6"; cmdEn = 1;
    fifoQ = '{8'h80, 8'h01, 8'h41, 8'h03, 8'h55};
    runIdle();
    e = '{8'h41, 8'h41, 8'h41, 8'h55}; chkLog("R2", e);
    chk(leadOut == 1'b1, "R4", "lead on", leadOut, 1);

    // R5 reserved lead value
    curReq = "R5";
    fifoQ = '{8'h80, 8'h07, 8'h43, 8'h01};
    runIdle();
    e = '{8'h43}; chkLog("R5", e);
    chk(leadOut == 1'b1, "R5", "lead kept", leadOut, 1);

    // R4 lead off
    curReq = "R4";
    fifoQ = '{8'h80, 8'h00, 8'h42, 8'h02};
    runIdle();
    e = '{8'h42, 8'h42}; chkLog("R4", e);
    chk(leadOut == 1'b0, "R4", "lead off", leadOut, 0);

    // R8 continuous with data already waiting
    curReq = "R8";
    fifoQ = '{8'h80, 8'h01, 8'h44, 8'h00, 8'h66};
    runIdle();
    e = '{8'h44, 8'h44, 8'h44, 8'h66}; chkLog("R8", e);

    // R7 continuous while FIFO empty
    curReq = "R7"; rdyPat = 0;
    fifoQ = '{8'h80, 8'h00, 8'h45, 8'h00};
    repeat (24) step();
    n45 = outLog.size();
    chk(n45 >= 15, "R7", "copies while empty", n45, 15);
    fifoQ.push_back(8'h77);
    runIdle();
    only45 = 1;
    for (int i = 0; i < outLog.size() - 1; i++) if (outLog[i] != 8'h45) only45 = 0;
    chk(only45, "R7", "only repeat char before new data", only45, 1);
    chk(outLog[outLog.size()-1] == 8'h77, "R7", "new data after stop",
        outLog[outLog.size()-1], 8'h77);
    outLog.delete();

    // R10 back-to-back commands
    curReq = "R10"; rdyPat = 1;
    fifoQ = '{8'h80, 8'h01, 8'h46, 8'h02, 8'h80, 8'h00, 8'h47, 8'h01, 8'h48};
    runIdle();
    e = '{8'h46, 8'h46, 8'h47, 8'h48}; chkLog("R10", e);

    // R6 maximum count, full 8-bit character
    curReq = "R6"; rdyPat = 0;
    fifoQ = '{8'h80, 8'h01, 8'hC3, 8'hFF};
    runIdle();
    e.delete();
    for (int i = 0; i < 255; i++) e.push_back(8'hC3);
    chkLog("R6", e);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule